// File: doc/BRIEF.md
# TDM Bus Input Timing Front End

This block sits at the receive edge of a time-division-multiplexed serial bus. It runs on a fast system clock and oversamples two slow timing signals: the serial input clock and its 8 kHz frame pulse. These come either from the external pins or from an on-chip loopback pair. The block picks the configured active edge of the serial clock and reads the frame pulse in the configured format. It also checks that pulses arrive exactly one frame apart.

Serial-to-parallel logic downstream receives a set of frame-aligned outputs: a frame start strobe, a strobe at the start of every bit, the bit position inside the current channel, and the channel number inside the frame. A lock flag reports stable framing. An error flag reports a pulse that came early or did not come.

A frame holds 2048, 1024 or 512 input clocks, chosen by a 2-bit rate code. Every data bit takes two input clocks, and every channel holds eight bits. Any change to the configuration inputs drops the framing state, and the block starts again from the next pulse.

Top module: `tdm_in_timing`

## Requirements
- R1: While reset is asserted and after its release, with no input clock edge yet, frame_start, bit_en, locked and frame_err are 0, and bit_idx and chan_idx are 0.
- R2: cfg_rate sets the frame length in input clocks: 2'b00 gives 2048, 2'b01 gives 1024, 2'b10 gives 512, and the reserved 2'b11 behaves as 2'b10. A pulse that arrives exactly that many active edges after the previous accepted pulse is accepted without an error, and such a frame holds frame-length/2 bit_en strobes.
- R3: Each bit spans two input clocks and each channel spans eight bits. bit_idx counts 0 to 7. chan_idx counts from 0 up to frame-length/16 - 1 (127, 63 or 31), advancing by one bit position per bit_en. frame_start comes with bit_en, bit_idx = 0 and chan_idx = 0.
- R4: With cfg_clk_pos = 0 (the reset default), the falling edge of the selected input clock is the active edge. With cfg_clk_pos = 1, the rising edge is the active edge. The frame pulse is sampled only on active edges.
- R5: With cfg_fp_gci = 0 (the default format), the frame pulse is active low. With cfg_fp_gci = 1, it is active high.
- R6: All outputs change on the third rising edge of clk after the selected input clock makes its active edge.
- R7: With cfg_loopback = 1, lb_ck and lb_fp replace ext_ck and ext_fp. Edges and pulses on the external pins then have no effect on any output.
- R8: When the active edge that ends a frame carries no pulse, frame_err is set and locked is cleared. The counters keep running and wrap, and no frame_start is produced.
- R9: A pulse that arrives before the end of the frame sets frame_err, clears locked, produces frame_start and restarts all counters from that pulse.
- R10: frame_err stays set until a pulse arrives at the expected count, and it clears on that pulse.
- R11: locked is set on the pulse that completes the second consecutive correctly spaced frame after the first accepted pulse, and not earlier.
- R12: Any change of cfg_rate, cfg_clk_pos, cfg_fp_gci or cfg_loopback clears locked and frame_err on the next clock. The first pulse after such a change is then accepted as a new reference without an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rate | input | 2 | Input clock rate code (frame length select) |
| cfg_clk_pos | input | 1 | 1 selects the rising edge of the input clock as the active edge |
| cfg_fp_gci | input | 1 | 1 selects an active-high frame pulse |
| cfg_loopback | input | 1 | 1 takes clock and frame pulse from the loopback pair |
| ext_ck | input | 1 | External serial input clock |
| ext_fp | input | 1 | External frame pulse |
| lb_ck | input | 1 | Internally generated loopback clock |
| lb_fp | input | 1 | Internally generated loopback frame pulse |
| frame_start | output | 1 | One-cycle strobe on an accepted frame pulse |
| bit_en | output | 1 | One-cycle strobe at the start of each bit |
| bit_idx | output | 3 | Bit position within the channel |
| chan_idx | output | 7 | Channel number within the frame |
| frame_err | output | 1 | Frame pulse missing or early |
| locked | output | 1 | Framing stable for two consecutive frames |

## Verification
Every output is registered. An active input-clock edge passes two synchroniser stages and one register, so frame_start, bit_en, the indices and both flags are due on the third system clock after that edge. A configuration change clears the flags on the very next clock. The bench drives each input clock half for several system clocks and samples on falling system-clock edges. For every pulse it records on which sample of the active half frame_start appeared, and it expects the third. The lock and error flags are read only after that half has ended. A separate monitor follows each bit_en, checks that the bit position advances by one, and counts strobes between frame starts. This lets frame length and index range be checked without reference to the edge timing.

// File: rtl/tdm_in_pkg.sv
package tdm_in_pkg;

  // Captured configuration, compared each cycle to detect a change.
  typedef struct packed {
    logic       lb;
    logic       gci;
    logic       pos;
    logic [1:0] rate;
  } tdm_cfg_t;

  // Rate code to right-shift of the longest frame; the reserved code maps to the slowest rate.
  function automatic logic [1:0] rate_shift(input logic [1:0] code);
    return (code == 2'b11) ? 2'd2 : code;
  endfunction

  // Input clocks per frame for a rate code.
  function automatic int frame_clks(input int max_clks, input logic [1:0] code);
    return max_clks >> rate_shift(code);
  endfunction

  // Channels per frame for a rate code.
  function automatic int chan_count(input int max_clks, input logic [1:0] code,
                                    input int clks_per_chan);
    return frame_clks(max_clks, code) / clks_per_chan;
  endfunction

endpackage

// File: rtl/tdm_in_edge.sv
module tdm_in_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_lb,
  input  logic pos_edge,
  input  logic fp_high,
  input  logic ext_ck,
  input  logic ext_fp,
  input  logic lb_ck,
  input  logic lb_fp,
  output logic tick,
  output logic fp_act
);
  logic                   raw_ck, raw_fp;
  logic [SYNC_STAGES-1:0] ck_sh, fp_sh;
  logic                   ck_prev, ck_now, fp_now;

  assign raw_ck = use_lb ? lb_ck : ext_ck;
  assign raw_fp = use_lb ? lb_fp : ext_fp;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ck_sh[i] <= 1'b0;
          fp_sh[i] <= 1'b0;
        end else begin
          ck_sh[i] <= raw_ck;
          fp_sh[i] <= raw_fp;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ck_sh[i] <= 1'b0;
          fp_sh[i] <= 1'b0;
        end else begin
          ck_sh[i] <= ck_sh[i-1];
          fp_sh[i] <= fp_sh[i-1];
        end
      end
    end
  end

  assign ck_now = ck_sh[SYNC_STAGES-1];
  assign fp_now = fp_sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_prev <= 1'b0;
    else        ck_prev <= ck_now;
  end

  // The selected edge of the synchronised clock, and the pulse level normalised to active-high.
  assign tick   = pos_edge ? (ck_now & ~ck_prev) : (~ck_now & ck_prev);
  assign fp_act = fp_high ? fp_now : ~fp_now;
endmodule

// File: rtl/tdm_in_frame_ctl.sv
module tdm_in_frame_ctl #(
  parameter int FRAME_CLKS_MAX = 2048,
  parameter int CLKS_PER_BIT   = 2,
  parameter int BITS_PER_CHAN  = 8,
  parameter int LOCK_FRAMES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  input  logic fp_act,
  input  logic [1:0] rate,
  output logic frame_start,
  output logic bit_en,
  output logic [$clog2(BITS_PER_CHAN)-1:0] bit_idx,
  output logic [$clog2(FRAME_CLKS_MAX)-$clog2(CLKS_PER_BIT)-$clog2(BITS_PER_CHAN)-1:0] chan_idx,
  output logic frame_err,
  output logic locked
);
  localparam int CNT_W  = $clog2(FRAME_CLKS_MAX);
  localparam int PH_W   = $clog2(CLKS_PER_BIT);
  localparam int BIT_W  = $clog2(BITS_PER_CHAN);
  localparam int CH_W   = CNT_W - PH_W - BIT_W;
  localparam int GOOD_W = $clog2(LOCK_FRAMES + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_nxt, last_cnt;
  logic [GOOD_W-1:0] good_q;
  logic have_ref_q, err_q, lock_q, fs_q, ben_q;
  logic at_last, ev_first, ev_good, ev_early, ev_miss, ev_accept, bit_start;

  assign last_cnt  = CNT_W'(tdm_in_pkg::frame_clks(FRAME_CLKS_MAX, rate) - 1);
  assign at_last   = have_ref_q && (cnt_q == last_cnt);
  assign ev_first  = tick && fp_act && !have_ref_q;
  assign ev_good   = tick && fp_act && at_last;
  assign ev_early  = tick && fp_act && have_ref_q && !at_last;
  assign ev_miss   = tick && !fp_act && at_last;
  assign ev_accept = ev_first || ev_good || ev_early;

  always_comb begin
    cnt_nxt = cnt_q;
    if (ev_accept)               cnt_nxt = '0;
    else if (tick && have_ref_q) cnt_nxt = at_last ? '0 : cnt_q + 1'b1;
  end

  if (CLKS_PER_BIT == 1) begin : g_bit_each
    assign bit_start = 1'b1;
  end else begin : g_bit_phase
    assign bit_start = (cnt_nxt[PH_W-1:0] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; good_q <= '0; have_ref_q <= 1'b0;
      err_q <= 1'b0; lock_q <= 1'b0; fs_q <= 1'b0; ben_q <= 1'b0;
    end else if (restart) begin
      cnt_q <= '0; good_q <= '0; have_ref_q <= 1'b0;
      err_q <= 1'b0; lock_q <= 1'b0; fs_q <= 1'b0; ben_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_nxt;
      have_ref_q <= have_ref_q || ev_first;
      fs_q       <= ev_accept;
      ben_q      <= tick && (have_ref_q || ev_first) && bit_start;
      if (ev_first || ev_early || ev_miss)
        good_q <= '0;
      else if (ev_good && good_q != GOOD_W'(LOCK_FRAMES))
        good_q <= good_q + 1'b1;
      if (ev_early || ev_miss)
        lock_q <= 1'b0;
      else if (ev_good && good_q >= GOOD_W'(LOCK_FRAMES - 1))
        lock_q <= 1'b1;
      if (ev_early || ev_miss) err_q <= 1'b1;
      else if (ev_good)        err_q <= 1'b0;
    end
  end

  assign frame_start = fs_q;
  assign bit_en      = ben_q;
  assign bit_idx     = cnt_q[PH_W +: BIT_W];
  assign chan_idx    = cnt_q[CNT_W-1 -: CH_W];
  assign frame_err   = err_q;
  assign locked      = lock_q;
endmodule

// File: rtl/tdm_in_timing.sv
module tdm_in_timing #(
  parameter int FRAME_CLKS_MAX = 2048,
  parameter int CLKS_PER_BIT   = 2,
  parameter int BITS_PER_CHAN  = 8,
  parameter int SYNC_STAGES    = 2,
  parameter int LOCK_FRAMES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [1:0] cfg_rate,
  input  logic cfg_clk_pos,
  input  logic cfg_fp_gci,
  input  logic cfg_loopback,
  input  logic ext_ck,
  input  logic ext_fp,
  input  logic lb_ck,
  input  logic lb_fp,
  output logic frame_start,
  output logic bit_en,
  output logic [$clog2(BITS_PER_CHAN)-1:0] bit_idx,
  output logic [$clog2(FRAME_CLKS_MAX)-$clog2(CLKS_PER_BIT)-$clog2(BITS_PER_CHAN)-1:0] chan_idx,
  output logic frame_err,
  output logic locked
);
  import tdm_in_pkg::*;

  // After a change, ignore edges until the new source has crossed every synchroniser stage.
  localparam int SETTLE = SYNC_STAGES + 1;
  localparam int SET_W  = $clog2(SETTLE + 1);

  tdm_cfg_t         cfg_now, cfg_q;
  logic [SET_W-1:0] settle_q;
  logic             cfg_chg, restart, tick, fp_act;

  assign cfg_now = '{lb: cfg_loopback, gci: cfg_fp_gci, pos: cfg_clk_pos, rate: cfg_rate};
  assign cfg_chg = (cfg_now != cfg_q);
  assign restart = cfg_chg || (settle_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      settle_q <= '0;
    end else begin
      cfg_q <= cfg_now;
      if (cfg_chg)              settle_q <= SET_W'(SETTLE);
      else if (settle_q != '0)  settle_q <= settle_q - 1'b1;
    end
  end

  tdm_in_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .use_lb   (cfg_loopback),
    .pos_edge (cfg_clk_pos),
    .fp_high  (cfg_fp_gci),
    .ext_ck   (ext_ck),
    .ext_fp   (ext_fp),
    .lb_ck    (lb_ck),
    .lb_fp    (lb_fp),
    .tick     (tick),
    .fp_act   (fp_act)
  );

  tdm_in_frame_ctl #(
    .FRAME_CLKS_MAX (FRAME_CLKS_MAX),
    .CLKS_PER_BIT   (CLKS_PER_BIT),
    .BITS_PER_CHAN  (BITS_PER_CHAN),
    .LOCK_FRAMES    (LOCK_FRAMES)
  ) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .tick        (tick),
    .fp_act      (fp_act),
    .rate        (cfg_rate),
    .frame_start (frame_start),
    .bit_en      (bit_en),
    .bit_idx     (bit_idx),
    .chan_idx    (chan_idx),
    .frame_err   (frame_err),
    .locked      (locked)
  );
endmodule

// File: rtl/tdm_in_timing_chk.sv
module tdm_in_timing_chk #(
  parameter int FRAME_CLKS_MAX = 2048,
  parameter int CLKS_PER_BIT   = 2,
  parameter int BITS_PER_CHAN  = 8,
  parameter int BIT_W          = 3,
  parameter int CH_W           = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_chg,
  input logic             tick,
  input logic [1:0]       cfg_rate,
  input logic             frame_start,
  input logic             bit_en,
  input logic [BIT_W-1:0] bit_idx,
  input logic [CH_W-1:0]  chan_idx,
  input logic             frame_err,
  input logic             locked
);
  p_fs_at_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (bit_en && bit_idx == '0 && chan_idx == '0));

  p_chan_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_chg |-> (int'(chan_idx) <
      tdm_in_pkg::chan_count(FRAME_CLKS_MAX, cfg_rate, CLKS_PER_BIT * BITS_PER_CHAN)));

  p_fs_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(tick));

  p_err_unlocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> !locked);

  p_lock_on_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> frame_start);

  p_cfg_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (!locked && !frame_err && !frame_start && !bit_en));
endmodule

bind tdm_in_timing tdm_in_timing_chk #(
  .FRAME_CLKS_MAX (FRAME_CLKS_MAX),
  .CLKS_PER_BIT   (CLKS_PER_BIT),
  .BITS_PER_CHAN  (BITS_PER_CHAN),
  .BIT_W          ($clog2(BITS_PER_CHAN)),
  .CH_W           ($clog2(FRAME_CLKS_MAX) - $clog2(CLKS_PER_BIT) - $clog2(BITS_PER_CHAN))
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_chg     (cfg_chg),
  .tick        (tick),
  .cfg_rate    (cfg_rate),
  .frame_start (frame_start),
  .bit_en      (bit_en),
  .bit_idx     (bit_idx),
  .chan_idx    (chan_idx),
  .frame_err   (frame_err),
  .locked      (locked)
);

// File: tb/tdm_in_timing_tb.sv
module tdm_in_timing_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_rate = 2'b10;
  logic       cfg_clk_pos = 1'b0, cfg_fp_gci = 1'b0, cfg_loopback = 1'b0;
  logic       ext_ck = 1'b1, ext_fp = 1'b1, lb_ck = 1'b1, lb_fp = 1'b1;
  logic       frame_start, bit_en, frame_err, locked;
  logic [2:0] bit_idx;
  logic [6:0] chan_idx;

  always #2 clk = ~clk;

  tdm_in_timing u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_rate(cfg_rate), .cfg_clk_pos(cfg_clk_pos),
    .cfg_fp_gci(cfg_fp_gci), .cfg_loopback(cfg_loopback), .ext_ck(ext_ck), .ext_fp(ext_fp),
    .lb_ck(lb_ck), .lb_fp(lb_fp), .frame_start(frame_start), .bit_en(bit_en),
    .bit_idx(bit_idx), .chan_idx(chan_idx), .frame_err(frame_err), .locked(locked));

  int checks = 0, errors = 0;
  int fs_at;
  int mon_bits = 0, mon_frame_bits = 0, mon_prev = 0, mon_max_chan = 0, mon_max_bit = 0;
  int seq_bad = 0, fs_total = 0;
  bit mon_have = 1'b0;

  function automatic int exp_clks(input logic [1:0] r);
    case (r)
      2'b00:   return 2048;
      2'b01:   return 1024;
      default: return 512;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Follows every bit strobe: position must advance by one, and strobes are counted per frame.
  always @(negedge clk) begin
    int pos;
    if (rst_n && bit_en) begin
      pos = int'(chan_idx) * 8 + int'(bit_idx);
      if (frame_start) begin
        fs_total++;
        if (pos != 0) seq_bad++;
        if (mon_have) mon_frame_bits = mon_bits;
        mon_bits = 1;
        mon_have = 1'b1;
      end else if (mon_have) begin
        if (pos != (mon_prev + 1) % (exp_clks(cfg_rate) / 2)) seq_bad++;
        mon_bits++;
      end
      mon_prev = pos;
      if (int'(chan_idx) > mon_max_chan) mon_max_chan = int'(chan_idx);
      if (int'(bit_idx) > mon_max_bit) mon_max_bit = int'(bit_idx);
    end
  end

  // One input clock: inactive half, then active half; the other source runs in antiphase.
  task automatic sclk(input bit pulse, input bit noise);
    logic pre;
    pre = cfg_clk_pos ? 1'b0 : 1'b1;
    @(negedge clk);
    if (cfg_loopback) begin
      lb_ck = pre;  lb_fp = cfg_fp_gci ? pulse : ~pulse;
      ext_ck = ~pre; ext_fp = cfg_fp_gci ? noise : ~noise;
    end else begin
      ext_ck = pre; ext_fp = cfg_fp_gci ? pulse : ~pulse;
      lb_ck = ~pre; lb_fp = cfg_fp_gci ? noise : ~noise;
    end
    repeat (3) @(negedge clk);
    if (cfg_loopback) begin lb_ck = ~pre; ext_ck = pre; end
    else begin ext_ck = ~pre; lb_ck = pre; end
    fs_at = 0;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (frame_start && fs_at == 0) fs_at = i;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) sclk(1'b0, 1'b0);
  endtask

  task automatic set_cfg(input logic [1:0] r, input bit pos, input bit gci, input bit lb);
    @(negedge clk);
    cfg_rate = r; cfg_clk_pos = pos; cfg_fp_gci = gci; cfg_loopback = lb;
    ext_ck = pos ? 1'b0 : 1'b1; lb_ck = ext_ck;
    ext_fp = gci ? 1'b0 : 1'b1; lb_fp = ext_fp;
    mon_have = 1'b0;
    @(negedge clk);
    check(!locked && !frame_err, "R12 config change clears flags", {locked, frame_err}, 0);
    idle(4);
  endtask

  task automatic mon_clear();
    mon_max_chan = 0; mon_max_bit = 0; seq_bad = 0; mon_frame_bits = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(!frame_start && !bit_en && !locked && !frame_err, "R1 strobes/flags in reset",
          {frame_start, bit_en, locked, frame_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(bit_idx == 0 && chan_idx == 0 && !locked && !frame_err, "R1 state after release",
          {chan_idx, bit_idx}, 0);
  endtask

  task automatic t_rate(input logic [1:0] r, input bit want_lock);
    int n;
    n = exp_clks(r);
    set_cfg(r, 1'b0, 1'b0, 1'b0);
    mon_clear();
    sclk(1'b1, 1'b0);
    check(fs_at == 3, "R6 frame_start on third clock after edge", fs_at, 3);
    check(!frame_err, "R12 first pulse after change accepted", frame_err, 0);
    idle(n - 1);
    sclk(1'b1, 1'b0);
    check(!frame_err && fs_at == 3, "R2 pulse at frame length accepted", frame_err, 0);
    check(mon_frame_bits == n / 2, "R2 bit strobes per frame", mon_frame_bits, n / 2);
    check(mon_max_chan == n / 16 - 1, "R3 last channel index", mon_max_chan, n / 16 - 1);
    check(mon_max_bit == 7, "R3 last bit index", mon_max_bit, 7);
    check(seq_bad == 0, "R3 index sequence", seq_bad, 0);
    check(!locked, "R11 no lock after one good frame", locked, 0);
    if (want_lock) begin
      idle(n - 1);
      sclk(1'b1, 1'b0);
      check(locked, "R11 lock after two good frames", locked, 1);
    end
  endtask

  task automatic t_format(input bit pos, input bit gci, input string req);
    set_cfg(2'b10, pos, gci, 1'b0);
    sclk(1'b1, 1'b0);
    check(fs_at == 3, {req, " pulse taken on active edge"}, fs_at, 3);
    idle(511);
    sclk(1'b1, 1'b0);
    check(fs_at == 3 && !frame_err, {req, " second pulse in step"}, fs_at, 3);
  endtask

  task automatic t_loop();
    int f0;
    set_cfg(2'b10, 1'b0, 1'b0, 1'b1);
    sclk(1'b1, 1'b0);
    f0 = fs_total;
    idle(200);
    sclk(1'b0, 1'b1);
    check(fs_at == 0 && !frame_err, "R7 external pulse ignored", fs_at, 0);
    idle(310);
    sclk(1'b1, 1'b0);
    check(fs_at == 3 && !frame_err, "R7 loopback pulse accepted", frame_err, 0);
    check(fs_total - f0 == 1, "R7 frame starts from loopback only", fs_total - f0, 1);
  endtask

  task automatic t_miss_early();
    set_cfg(2'b10, 1'b0, 1'b0, 1'b0);
    sclk(1'b1, 1'b0); idle(511);
    sclk(1'b1, 1'b0); idle(511);
    sclk(1'b1, 1'b0);
    check(locked, "R8 locked before missing pulse", locked, 1);
    idle(511);
    sclk(1'b0, 1'b0);
    check(frame_err && !locked, "R8 missing pulse flagged", {frame_err, locked}, 2);
    check(fs_at == 0, "R8 no frame_start on missing pulse", fs_at, 0);
    idle(511);
    sclk(1'b1, 1'b0);
    check(fs_at == 3 && !frame_err, "R10 error cleared at expected count", frame_err, 0);
    check(!locked, "R10 lock not yet regained", locked, 0);
    idle(99);
    sclk(1'b1, 1'b0);
    check(frame_err && fs_at == 3 && !locked, "R9 early pulse flagged and accepted",
          {frame_err, locked}, 2);
    idle(511);
    sclk(1'b1, 1'b0);
    check(!frame_err, "R10 error cleared after resync", frame_err, 1'b0);
    check(mon_frame_bits == 256, "R9 counters restarted at early pulse", mon_frame_bits, 256);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_rate(2'b10, 1'b1);
    t_rate(2'b11, 1'b0);
    t_rate(2'b01, 1'b0);
    t_rate(2'b00, 1'b0);
    t_format(1'b1, 1'b0, "R4");
    t_format(1'b0, 1'b1, "R5");
    t_loop();
    t_miss_early();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule